// File: doc/BRIEF.md
# Instruction Decoder and Immediate Extender

This block turns one 32-bit instruction word into the control signals a simple load/store datapath needs, and produces the 32-bit immediate that instruction uses. It is purely combinational. The instruction word goes in, and the decoded fields appear in the same cycle. The fields are the source and destination register numbers, the ALU operation, the ALU operand select, the write-back controls, the memory controls, the branch kind and the extended immediate.

Two formats are accepted. The register format takes its operation from a function field. The immediate format carries a 16-bit constant. The constant is widened in one of four ways, chosen by the opcode: sign extension, zero fill, placement in the upper half, or sign extension scaled to a word offset for branches. Any opcode or function code outside the supported set is reported as illegal. In that case every state-changing control is held inactive.

Top module: `instr_decoder`

## Requirements
- R1: `src1_addr` is instruction bits 25:21 and `dst_addr` is bits 20:16, for every instruction word.
- R2: Opcode 100000 with function field (bits 5:0) add 110000, sub 110001, nand 110010, or 110011, not 110100, sra 111000, sll 111001, srl 111010, rol 111100, ror 111101 gives `alu_op` 0000, 0001, 0010, 0011, 0100, 1000, 1010, 1001, 1100, 1101 respectively. It also gives `reg_we`=1, `alu_src_imm`=0, `wb_sel`=00 (ALU result), no memory access and `br_type`=00 (none).
- R3: Opcode 111000 writes the sign-extended immediate. Opcode 111001 writes the immediate in bits 31:16 with bits 15:0 zero. Both give `reg_we`=1 and `wb_sel`=10 (immediate).
- R4: Opcode 110000 adds (`alu_op` 0000) the sign-extended immediate. Opcode 110010 nands (0010) with the zero-filled immediate. Opcode 110011 ors (0011) with the zero-filled immediate. All three give `alu_src_imm`=1, `reg_we`=1 and `wb_sel`=00.
- R5: Opcode 111111 gives `br_type`=01 (always). Opcode 000000 gives 10 (if equal) and opcode 000001 gives 11 (if not equal), both with `alu_op` 0001. For all three, `imm_ext` is the sign-extended immediate shifted left by 2, and there is no register or memory write.
- R6: Opcode 000011 (byte load) and 001111 (word load) give `mem_rd`=1, `reg_we`=1 and `wb_sel`=01. Opcode 000111 (byte store) and 011111 (word store) give `mem_wr`=1 and `reg_we`=0. `mem_byte` is 1 for the byte forms only. All four give `alu_op` 0000, `alu_src_imm`=1 and a sign-extended `imm_ext`.
- R7: `src2_addr` is bits 20:16 for stores and for the two conditional branches, and bits 15:11 for every other instruction.
- R8: Any other opcode, or opcode 100000 with any other function code, gives `illegal`=1, `reg_we`=0, `mem_rd`=0, `mem_wr`=0, `mem_byte`=0, `br_type`=00, `alu_op` 0000, `alu_src_imm`=0, `wb_sel`=00 and `imm_ext`=0. Legal instructions give `illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| src1_addr | output | 5 | First source register number |
| src2_addr | output | 5 | Second source register number |
| dst_addr | output | 5 | Destination register number |
| alu_op | output | 4 | ALU operation code |
| alu_src_imm | output | 1 | 1: ALU second operand is the immediate |
| reg_we | output | 1 | Register file write enable |
| wb_sel | output | 2 | Write-back source: 00 ALU, 01 memory, 10 immediate |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_byte | output | 1 | 1: byte access, 0: word access |
| br_type | output | 2 | 00 none, 01 always, 10 if equal, 11 if not equal |
| imm_ext | output | 32 | Extended immediate |
| illegal | output | 1 | Unsupported opcode or function code |

## Verification
Every output is a combinational function of `instr`, so each result is due in the same cycle that the word is applied. No register sits on any path. The bench changes `instr` just after a rising edge and samples all outputs at the following falling edge, half a period later, when the logic has settled. At that point it compares the full output set against its own model. Immediates are chosen to sit at the sign boundary so that each widening mode shows its effect in the upper bits.

// File: rtl/instr_decoder.sv
module instr_decoder (
  input  logic [31:0] instr,
  output logic [4:0]  src1_addr,
  output logic [4:0]  src2_addr,
  output logic [4:0]  dst_addr,
  output logic [3:0]  alu_op,
  output logic        alu_src_imm,
  output logic        reg_we,
  output logic [1:0]  wb_sel,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        mem_byte,
  output logic [1:0]  br_type,
  output logic [31:0] imm_ext,
  output logic        illegal
);
  localparam logic [5:0] OP_REG = 6'b100000, OP_LI = 6'b111000, OP_LUI = 6'b111001,
                         OP_ADDI = 6'b110000, OP_NANDI = 6'b110010, OP_ORI = 6'b110011,
                         OP_B = 6'b111111, OP_BEQ = 6'b000000, OP_BNE = 6'b000001,
                         OP_LB = 6'b000011, OP_SB = 6'b000111, OP_LW = 6'b001111,
                         OP_SW = 6'b011111;
  localparam logic [3:0] A_ADD = 4'b0000, A_SUB = 4'b0001, A_NAND = 4'b0010, A_OR = 4'b0011,
                         A_NOT = 4'b0100, A_SRA = 4'b1000, A_SRL = 4'b1001, A_SLL = 4'b1010,
                         A_ROL = 4'b1100, A_ROR = 4'b1101;
  localparam logic [1:0] WB_ALU = 2'b00, WB_MEM = 2'b01, WB_IMM = 2'b10;
  localparam logic [1:0] BR_NONE = 2'b00, BR_ALWAYS = 2'b01, BR_EQ = 2'b10, BR_NE = 2'b11;

  typedef enum logic [2:0] {X_NONE, X_SIGN, X_ZERO, X_UPPER, X_WORD} ext_t;

  wire [5:0]  opc = instr[31:26];
  wire [5:0]  fn  = instr[5:0];
  wire [15:0] imm = instr[15:0];

  ext_t ext;
  logic sel_rd;

  assign src1_addr = instr[25:21];
  assign dst_addr  = instr[20:16];
  assign src2_addr = sel_rd ? instr[20:16] : instr[15:11];

  always_comb begin
    case (ext)
      X_SIGN:  imm_ext = {{16{imm[15]}}, imm};
      X_ZERO:  imm_ext = {16'h0, imm};
      X_UPPER: imm_ext = {imm, 16'h0};
      X_WORD:  imm_ext = {{14{imm[15]}}, imm, 2'b00};
      default: imm_ext = '0;
    endcase
  end

  always_comb begin
    alu_op = A_ADD; alu_src_imm = 1'b0; reg_we = 1'b0; wb_sel = WB_ALU;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_byte = 1'b0; br_type = BR_NONE;
    ext = X_NONE; sel_rd = 1'b0; illegal = 1'b0;
    case (opc)
      OP_REG: begin
        reg_we = 1'b1;
        case (fn)
          6'b110000: alu_op = A_ADD;
          6'b110001: alu_op = A_SUB;
          6'b110010: alu_op = A_NAND;
          6'b110011: alu_op = A_OR;
          6'b110100: alu_op = A_NOT;
          6'b111000: alu_op = A_SRA;
          6'b111001: alu_op = A_SLL;
          6'b111010: alu_op = A_SRL;
          6'b111100: alu_op = A_ROL;
          6'b111101: alu_op = A_ROR;
          default: begin reg_we = 1'b0; illegal = 1'b1; end
        endcase
      end
      OP_LI:    begin reg_we = 1'b1; wb_sel = WB_IMM; ext = X_SIGN; end
      OP_LUI:   begin reg_we = 1'b1; wb_sel = WB_IMM; ext = X_UPPER; end
      OP_ADDI:  begin reg_we = 1'b1; alu_src_imm = 1'b1; ext = X_SIGN; end
      OP_NANDI: begin reg_we = 1'b1; alu_src_imm = 1'b1; ext = X_ZERO; alu_op = A_NAND; end
      OP_ORI:   begin reg_we = 1'b1; alu_src_imm = 1'b1; ext = X_ZERO; alu_op = A_OR; end
      OP_B:     begin br_type = BR_ALWAYS; ext = X_WORD; end
      OP_BEQ:   begin br_type = BR_EQ; ext = X_WORD; alu_op = A_SUB; sel_rd = 1'b1; end
      OP_BNE:   begin br_type = BR_NE; ext = X_WORD; alu_op = A_SUB; sel_rd = 1'b1; end
      OP_LB, OP_LW: begin
        reg_we = 1'b1; wb_sel = WB_MEM; mem_rd = 1'b1; alu_src_imm = 1'b1; ext = X_SIGN;
        mem_byte = (opc == OP_LB);
      end
      OP_SB, OP_SW: begin
        mem_wr = 1'b1; alu_src_imm = 1'b1; ext = X_SIGN; sel_rd = 1'b1;
        mem_byte = (opc == OP_SB);
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] instr,
  input logic [4:0]  src2_addr,
  input logic        reg_we,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        mem_byte,
  input logic [1:0]  br_type,
  input logic [31:0] imm_ext,
  input logic        illegal
);
  always_comb begin
    if (illegal)
      assert_illegal_quiet_R8: assert (!reg_we && !mem_rd && !mem_wr && br_type == 2'b00)
        else $error("illegal word left a control active");
    assert_mem_exclusive_R6: assert (!(mem_rd && mem_wr))
      else $error("read and write together");
    if (mem_byte)
      assert_byte_needs_access_R6: assert (mem_rd || mem_wr)
        else $error("byte select without access");
    if (br_type != 2'b00)
      assert_branch_no_write_R5: assert (!reg_we && !mem_wr && imm_ext[1:0] == 2'b00)
        else $error("branch wrote state or offset not word aligned");
    if (instr[31:26] == 6'b111001)
      assert_upper_half_R3: assert (imm_ext == {instr[15:0], 16'h0})
        else $error("upper placement wrong");
    if (mem_wr)
      assert_store_src2_R7: assert (src2_addr == instr[20:16])
        else $error("store data register not taken from bits 20:16");
  end
endmodule

bind instr_decoder instr_decoder_chk u_chk (.*);

// File: tb/instr_decoder_bench.sv
module instr_decoder_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic [4:0]  src1_addr, src2_addr, dst_addr;
  logic [3:0]  alu_op;
  logic        alu_src_imm, reg_we, mem_rd, mem_wr, mem_byte, illegal;
  logic [1:0]  wb_sel, br_type;
  logic [31:0] imm_ext;

  instr_decoder u_instr_decoder (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // reference: returns {src1,src2,dst,alu,srcimm,we,wb,rd,wr,byte,br,imm,ill}
  function automatic logic [60:0] model(input logic [31:0] w, output string tag);
    int op = w[31:26], f = w[5:0];
    int s = w[15:0];
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    logic [3:0] a = 0; logic si = 0, we = 0, r = 0, wr = 0, by = 0, ill = 0, use_rd = 0;
    logic [1:0] wb = 0, br = 0; logic [31:0] im = 0;
    tag = "R8";
    if (op == 32) begin
      tag = "R2"; we = 1;
      if (f == 48) a = 0; else if (f == 49) a = 1; else if (f == 50) a = 2;
      else if (f == 51) a = 3; else if (f == 52) a = 4; else if (f == 56) a = 8;
      else if (f == 57) a = 10; else if (f == 58) a = 9; else if (f == 60) a = 12;
      else if (f == 61) a = 13; else begin we = 0; ill = 1; tag = "R8"; end
    end else if (op == 56 || op == 57) begin
      tag = "R3"; we = 1; wb = 2; im = (op == 56) ? sx : (s << 16);
    end else if (op == 48 || op == 50 || op == 51) begin
      tag = "R4"; we = 1; si = 1;
      im = (op == 48) ? sx : s; a = (op == 48) ? 0 : (op == 50) ? 2 : 3;
    end else if (op == 63 || op == 0 || op == 1) begin
      tag = "R5"; im = sx * 4;
      br = (op == 63) ? 1 : (op == 0) ? 2 : 3;
      if (op != 63) begin a = 1; use_rd = 1; end
    end else if (op == 3 || op == 15 || op == 7 || op == 31) begin
      tag = "R6"; si = 1; im = sx; by = (op == 3 || op == 7);
      if (op == 3 || op == 15) begin r = 1; we = 1; wb = 1; end
      else begin wr = 1; use_rd = 1; end
    end else ill = 1;
    return {w[25:21], use_rd ? w[20:16] : w[15:11], w[20:16], a, si, we, wb, r, wr, by, br, im, ill};
  endfunction

  task automatic apply(input logic [31:0] w);
    logic [60:0] exp_v, got;
    string tag;
    @(posedge clk);
    #0.5 instr = w;
    @(negedge clk);
    exp_v = model(w, tag);
    got = {src1_addr, src2_addr, dst_addr, alu_op, alu_src_imm, reg_we, wb_sel,
           mem_rd, mem_wr, mem_byte, br_type, imm_ext, illegal};
    checks++;
    if (got[45:32] != exp_v[45:32] || got[0] != exp_v[0] || got[31:1] != exp_v[31:1]) begin
      failures++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, got, exp_v);
    end
    checks++; // R1 and R7 register fields
    if (got[60:46] != exp_v[60:46]) begin
      failures++;
      $display("FAIL R1/R7 instr=%h actual=%h expected=%h", w, got[60:46], exp_v[60:46]);
    end
  endtask

  localparam int NIMM = 5;
  logic [15:0] imms [NIMM] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    // R2 and R8: every function code under the register opcode
    for (int f = 0; f < 64; f++)
      apply({6'b100000, 5'd3, 5'd17, 5'd29, 5'b10101, f[5:0]});
    // R3 R4 R5 R6 R8 R7: every opcode with boundary immediates
    for (int op = 0; op < 64; op++)
      for (int k = 0; k < NIMM; k++)
        apply({op[5:0], 5'(op + k), 5'(31 - op), imms[k]});
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule